// File: doc/BRIEF.md
# Decode-Stage Branch and Jump Resolver

This block sits in the decode stage of a five-stage in-order pipeline and settles control transfers there, one stage earlier than the execute stage would. For a not-equal branch it compares the two operands, which have already been forwarded. If they differ, it redirects fetch to the current PC plus the word-scaled, sign-extended 16-bit offset. For the jump class it always redirects, to a target built from the PC's region bits and the 26-bit index field. Prediction is static not-taken: fetch runs sequentially, and a redirect cancels exactly the one instruction that was fetched behind the branch or jump.

For jumps it also produces the linking controls. The link select tells writeback to store PC+4 instead of the ALU result. The destination index depends on the RegWrite bit: it becomes the link register (all ones, index 31) when RegWrite is set, and register 0 when it is clear. Register 0 is never written and never forwarded, so a plain jump leaves no hazard behind it.

The redirect flag and target are combinational. The fetch stage samples them at the next clock edge. The flush output clears the write enables of the fetch/decode register, which turns the wrong-path instruction into a bubble. The block then treats the slot that follows as cancelled. All pins are plain control and status wires: the block sits inside a stage that advances every cycle, so no valid/ready handshake applies.

Top module: `branch_jump_resolver`

## Requirements
- R1: When `cls_i` is 1 (not-equal branch), the slot is not cancelled, and `opa_i` differs from `opb_i`, `redirect_o` is 1 and `target_o` equals `pc_i` plus the sign-extended bits [15:0] of `instr_idx_i`, shifted left by two, modulo 2^32.
- R2: When `cls_i` is 1 and `opa_i` equals `opb_i`, `redirect_o` and `flush_o` are 0.
- R3: When `cls_i` is 2 (jump class) and the slot is not cancelled, `redirect_o` and `link_sel_o` are 1, and `target_o` is `{pc_i[31:28], instr_idx_i[25:0], 2'b00}`.
- R4: A jump-class slot with `reg_write_i` set drives `dest_o` to 31. `link_value_o` always equals `pc_i` + 4.
- R5: A jump-class slot with `reg_write_i` clear drives `dest_o` to 0.
- R6: When `cls_i` is 0 or 3 (no control transfer), `redirect_o` and `link_sel_o` are 0 and `dest_o` equals `dest_i`.
- R7: `flush_o` is 1 in exactly the cycles in which `redirect_o` is 1.
- R8: In the cycle after a cycle with `redirect_o` high, the decode slot is cancelled, whatever the inputs. In that cycle `redirect_o`, `flush_o` and `link_sel_o` are 0 and `dest_o` is 0. The cycle after that resolves normally.
- R9: While `rst_n` is low, and in the first cycle after it rises, no slot is cancelled, so the outputs follow R1 to R6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| pc_i | input | 32 | PC of the instruction in decode |
| instr_idx_i | input | 26 | Low 26 bits of the instruction word (offset in [15:0]) |
| opa_i | input | 32 | First forwarded register operand |
| opb_i | input | 32 | Second forwarded register operand |
| cls_i | input | 2 | Opcode class: 0 none, 1 not-equal branch, 2 jump, 3 none |
| reg_write_i | input | 1 | Decoded register-write control |
| dest_i | input | 5 | Destination index from the main decoder |
| redirect_o | output | 1 | Fetch must load `target_o` at the next edge |
| target_o | output | 32 | Redirect address; meaningful only with `redirect_o` |
| flush_o | output | 1 | Clears write enables of the fetch/decode register |
| link_sel_o | output | 1 | Writeback selects `link_value_o` over the ALU result |
| dest_o | output | 5 | Adjusted destination index |
| link_value_o | output | 32 | PC + 4 |

## Verification
Assertions check several rules on every cycle. A redirect is never followed by a second redirect or flush in the next cycle. Equal operands never take a branch, and the no-transfer classes never redirect or link. A jump's target keeps the PC's region bits, and the link select always comes with a destination of 31 or 0 that agrees with RegWrite. Other properties need the bench's scenarios. These are the exact arithmetic of positive and negative branch offsets, wrap of the jump region at 256 MB boundaries, and resolution returning after a cancelled slot. The reset behaviour is also shown only by the bench, which compares every output against a model that tracks the cancelled-slot state on its own.

// File: rtl/bjr_pkg.sv
`timescale 1ns/1ps
package bjr_pkg;
  typedef enum logic [1:0] {
    CLS_NONE = 2'd0,
    CLS_BNE  = 2'd1,
    CLS_JUMP = 2'd2,
    CLS_RSVD = 2'd3
  } op_class_e;
endpackage

// File: rtl/bjr_target_gen.sv
`timescale 1ns/1ps
module bjr_target_gen #(
  parameter int XLEN   = 32,
  parameter int IMM_W  = 16,
  parameter int JIDX_W = 26
) (
  input  logic [XLEN-1:0]   pc_i,
  input  logic [JIDX_W-1:0] idx_i,
  output logic [XLEN-1:0]   br_target_o,
  output logic [XLEN-1:0]   jmp_target_o,
  output logic [XLEN-1:0]   pc_plus4_o
);
  localparam int EXT_W    = XLEN - IMM_W - 2;
  localparam int REGION_W = XLEN - JIDX_W - 2;

  logic [IMM_W-1:0] imm;
  logic [XLEN-1:0]  offset;

  assign imm    = idx_i[IMM_W-1:0];
  // sign extend, then scale to a word offset
  assign offset = {{EXT_W{imm[IMM_W-1]}}, imm, 2'b00};

  assign br_target_o  = pc_i + offset;
  assign jmp_target_o = {pc_i[XLEN-1 -: REGION_W], idx_i, 2'b00};
  assign pc_plus4_o   = pc_i + XLEN'(4);
endmodule

// File: rtl/bjr_cond_cmp.sv
`timescale 1ns/1ps
module bjr_cond_cmp #(
  parameter int XLEN   = 32,
  parameter int LANE_W = 8
) (
  input  logic [XLEN-1:0] a_i,
  input  logic [XLEN-1:0] b_i,
  output logic            ne_o
);
  localparam int LANES = XLEN / LANE_W;

  logic [LANES-1:0] lane_ne;

  // per-lane difference detect, then one wide OR
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign lane_ne[g] = |(a_i[g*LANE_W +: LANE_W] ^ b_i[g*LANE_W +: LANE_W]);
  end

  assign ne_o = |lane_ne;
endmodule

// File: rtl/bjr_link_ctl.sv
`timescale 1ns/1ps
module bjr_link_ctl #(
  parameter int REG_AW = 5
) (
  input  logic              is_jump_i,
  input  logic              kill_i,
  input  logic              reg_write_i,
  input  logic [REG_AW-1:0] dest_i,
  output logic              link_sel_o,
  output logic [REG_AW-1:0] dest_o
);
  localparam logic [REG_AW-1:0] LINK_REG = '1;
  localparam logic [REG_AW-1:0] NULL_REG = '0;

  always_comb begin
    link_sel_o = 1'b0;
    dest_o     = dest_i;
    if (kill_i) begin
      dest_o = NULL_REG;
    end else if (is_jump_i) begin
      link_sel_o = 1'b1;
      dest_o     = reg_write_i ? LINK_REG : NULL_REG;
    end
  end
endmodule

// File: rtl/branch_jump_resolver.sv
`timescale 1ns/1ps
module branch_jump_resolver #(
  parameter int XLEN   = 32,
  parameter int IMM_W  = 16,
  parameter int JIDX_W = 26,
  parameter int REG_AW = 5,
  parameter int LANE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [XLEN-1:0]   pc_i,
  input  logic [JIDX_W-1:0] instr_idx_i,
  input  logic [XLEN-1:0]   opa_i,
  input  logic [XLEN-1:0]   opb_i,
  input  logic [1:0]        cls_i,
  input  logic              reg_write_i,
  input  logic [REG_AW-1:0] dest_i,
  output logic              redirect_o,
  output logic [XLEN-1:0]   target_o,
  output logic              flush_o,
  output logic              link_sel_o,
  output logic [REG_AW-1:0] dest_o,
  output logic [XLEN-1:0]   link_value_o
);
  import bjr_pkg::*;

  localparam int REGION_W = XLEN - JIDX_W - 2;
  localparam logic [REG_AW-1:0] LINK_REG = '1;

  logic            squash_q;
  logic            is_bne, is_jump, ops_ne;
  logic            take_br, take_jmp;
  logic [XLEN-1:0] br_target, jmp_target;

  assign is_bne  = (cls_i == CLS_BNE);
  assign is_jump = (cls_i == CLS_JUMP);

  bjr_target_gen #(.XLEN(XLEN), .IMM_W(IMM_W), .JIDX_W(JIDX_W)) u_tgt (
    .pc_i         (pc_i),
    .idx_i        (instr_idx_i),
    .br_target_o  (br_target),
    .jmp_target_o (jmp_target),
    .pc_plus4_o   (link_value_o)
  );

  bjr_cond_cmp #(.XLEN(XLEN), .LANE_W(LANE_W)) u_cmp (
    .a_i  (opa_i),
    .b_i  (opb_i),
    .ne_o (ops_ne)
  );

  bjr_link_ctl #(.REG_AW(REG_AW)) u_link (
    .is_jump_i   (is_jump),
    .kill_i      (squash_q),
    .reg_write_i (reg_write_i),
    .dest_i      (dest_i),
    .link_sel_o  (link_sel_o),
    .dest_o      (dest_o)
  );

  // static not-taken: only a resolved transfer leaves the sequential path
  assign take_br    = !squash_q && is_bne && ops_ne;
  assign take_jmp   = !squash_q && is_jump;
  assign redirect_o = take_br || take_jmp;
  assign target_o   = take_jmp ? jmp_target : br_target;
  assign flush_o    = redirect_o;

  // the slot behind a redirect is the wrong-path fetch: cancel it once
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) squash_q <= 1'b0;
    else        squash_q <= redirect_o;
  end

  AST_BNE_EQ_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (is_bne && opa_i == opb_i) |-> !redirect_o);  // R2
  AST_NO_XFER_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (cls_i == CLS_NONE || cls_i == CLS_RSVD) |-> (!redirect_o && !link_sel_o));  // R6
  AST_ONE_SLOT_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
    redirect_o |=> (!redirect_o && !flush_o && !link_sel_o));  // R8
  AST_JUMP_REGION: assert property (@(posedge clk) disable iff (!rst_n)
    (is_jump && redirect_o) |-> (target_o[XLEN-1 -: REGION_W] == pc_i[XLEN-1 -: REGION_W]));  // R3
  AST_LINK_DEST: assert property (@(posedge clk) disable iff (!rst_n)
    (link_sel_o && reg_write_i) |-> (dest_o == LINK_REG));  // R4
  AST_NULL_DEST: assert property (@(posedge clk) disable iff (!rst_n)
    (link_sel_o && !reg_write_i) |-> (dest_o == '0));  // R5
endmodule

// File: tb/sim_branch_jump_resolver.sv
`timescale 1ns/1ps
module sim_branch_jump_resolver;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] pc, opa, opb;
  logic [25:0] idx;
  logic [1:0]  cls;
  logic        rw;
  logic [4:0]  dst;
  logic        redirect, flush, link_sel;
  logic [31:0] target, link_value;
  logic [4:0]  dest;

  int total = 0;
  int fails = 0;
  bit done  = 1'b0;
  bit exp_sq = 1'b0;

  always #5 clk = ~clk;

  branch_jump_resolver u0 (
    .clk(clk), .rst_n(rst_n), .pc_i(pc), .instr_idx_i(idx), .opa_i(opa), .opb_i(opb),
    .cls_i(cls), .reg_write_i(rw), .dest_i(dst), .redirect_o(redirect), .target_o(target),
    .flush_o(flush), .link_sel_o(link_sel), .dest_o(dest), .link_value_o(link_value)
  );

  function automatic logic [31:0] br_tgt(input logic [31:0] p, input logic [15:0] o);
    logic [31:0] s;
    s = {{16{o[15]}}, o};
    return p + (s << 2);
  endfunction

  function automatic logic [31:0] j_tgt(input logic [31:0] p, input logic [25:0] i);
    return {p[31:28], i, 2'b00};
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic drive(input logic [1:0] c, input logic w, input logic [31:0] p,
                       input logic [25:0] i, input logic [31:0] a, input logic [31:0] b,
                       input logic [4:0] d);
    cls = c; rw = w; pc = p; idx = i; opa = a; opb = b; dst = d;
  endtask

  // compare all outputs against the model for the current cancel state
  task automatic compare();
    bit r, l;
    logic [4:0] ed;
    string tag;
    r = 0; l = 0; ed = dst;
    tag = (cls == 2'd1) ? ((opa != opb) ? "R1" : "R2") : (cls == 2'd2) ? "R3" : "R6";
    if (exp_sq) begin
      tag = "R8"; ed = 5'd0;
    end else if (cls == 2'd1) begin
      r = (opa != opb);
    end else if (cls == 2'd2) begin
      r = 1; l = 1; ed = rw ? 5'd31 : 5'd0;
    end
    chk({tag, " redirect"}, {31'd0, redirect}, {31'd0, r});
    chk({tag, " link_sel"}, {31'd0, link_sel}, {31'd0, l});
    chk("R7 flush", {31'd0, flush}, {31'd0, r});
    chk((cls == 2'd2 && !exp_sq) ? (rw ? "R4 dest" : "R5 dest") : {tag, " dest"},
        {27'd0, dest}, {27'd0, ed});
    chk("R4 link_value", link_value, pc + 32'd4);
    if (r && cls == 2'd1) chk("R1 target", target, br_tgt(pc, idx[15:0]));
    if (r && cls == 2'd2) chk("R3 target", target, j_tgt(pc, idx));
    exp_sq = r;
  endtask

  task automatic step(input logic [1:0] c, input logic w, input logic [31:0] p,
                      input logic [25:0] i, input logic [31:0] a, input logic [31:0] b,
                      input logic [4:0] d);
    @(negedge clk);
    drive(c, w, p, i, a, b, d);
    #2;
    compare();
  endtask

  initial begin
    #1_500_000;
    if (!done) begin
      total++; fails++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    int unsigned seed;
    seed = $urandom(32'd2024);
    // R9: during reset nothing is cancelled; a taken branch resolves
    drive(2'd1, 1'b0, 32'h0000_1000, 26'h0000004, 32'd1, 32'd2, 5'd3);
    @(negedge clk); @(negedge clk);
    #2;
    chk("R9 redirect in reset", {31'd0, redirect}, 32'd1);
    chk("R9 target in reset", target, 32'h0000_1010);
    drive(2'd0, 1'b1, 32'h0, 26'h0, 32'd0, 32'd0, 5'd9);
    #1;
    chk("R9 dest in reset", {27'd0, dest}, 32'd9);
    @(negedge clk);
    rst_n = 1'b1;
    exp_sq = 0;
    // R9: first slot after reset resolves
    step(2'd1, 1'b0, 32'h0000_1000, 26'h000FFFF, 32'd5, 32'd6, 5'd0);   // R1 negative offset
    chk("R1 negative target", target, 32'h0000_0FFC);
    step(2'd2, 1'b1, 32'h0000_2000, 26'h3FFFFFF, 32'd0, 32'd0, 5'd7);   // R8 cancelled jump
    step(2'd1, 1'b0, 32'h0000_1000, 26'h0007FFF, 32'd5, 32'd6, 5'd0);   // R1 max positive
    chk("R1 positive target", target, 32'h0002_0FFC);
    step(2'd0, 1'b0, 32'h0, 26'h0, 32'd0, 32'd0, 5'd12);                // R8 cancelled
    step(2'd1, 1'b1, 32'h0000_3000, 26'h0000010, 32'hAB, 32'hAB, 5'd4); // R2 equal
    step(2'd2, 1'b1, 32'h0FFF_FFFC, 26'h3FFFFFF, 32'd0, 32'd0, 5'd2);   // R3 R4 region top
    chk("R3 region edge", target, 32'h0FFF_FFFC);
    chk("R4 link past region", link_value, 32'h1000_0000);
    step(2'd3, 1'b0, 32'h0, 26'h0, 32'd0, 32'd0, 5'd17);                // R8 cancelled
    step(2'd2, 1'b0, 32'hF000_0000, 26'h0000000, 32'd0, 32'd0, 5'd9);   // R3 R5 plain jump
    chk("R5 null dest", {27'd0, dest}, 32'd0);
    step(2'd3, 1'b1, 32'h0, 26'h0, 32'd1, 32'd2, 5'd21);                // R8 cancelled
    step(2'd3, 1'b1, 32'h0, 26'h0, 32'd1, 32'd2, 5'd21);                // R6 reserved class
    chk("R6 dest pass", {27'd0, dest}, 32'd21);
    step(2'd1, 1'b0, 32'hFFFF_FFF0, 26'h0000008, 32'h8000_0000, 32'h0, 5'd0); // R1 wrap
    chk("R1 wrap target", target, 32'h0000_0010);
    for (int k = 0; k < 3000; k++) begin
      logic [1:0] c;
      logic [31:0] a, b;
      c = 2'($urandom);
      a = $urandom;
      b = ($urandom % 3 == 0) ? a : $urandom;
      step(c, 1'($urandom), $urandom, 26'($urandom), a, b, 5'($urandom));
    end
    done = 1'b1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule